// File: doc/BRIEF.md
# Burst Arbitration Point Generator

This block sits beside the arbiter of one slave port of an AHB-style interconnect. It watches the transfers of whichever master currently owns that port. It raises a single-cycle flag that marks a transfer boundary at which the arbiter may hand the port to another master. Grant selection, address decoding and data paths belong to the arbiter and are not part of this block.

Two mechanisms can place a break inside a long access. The first is a beat limit on undefined-length (INCR) bursts. It is selected by a small code, and the default code means no limit. With no limit set, an INCR burst breaks only where it crosses a 1 KB address boundary. The second is a slot watchdog. It reloads a countdown from the programmed slot length at every arbitration point and counts down one step per clock. Once it reaches zero, it forces a break at the next completed beat.

Fixed-length bursts break only on their final beat. Single transfers and idle cycles break at once.

Top module: `arbpt_gen`

## Requirements
- R1: `arb_pt_o` is 0 while `rst_ni` is low and on the first cycle after reset is released, before any clock edge.
- R2: With `hready_i` high, an IDLE transfer (`htrans_i`=0) gives `arb_pt_o`=1. A BUSY transfer (`htrans_i`=1) never gives a pulse.
- R3: A completed NONSEQ/SEQ beat (`htrans_i`=2/3, `hready_i`=1) of a SINGLE burst (`hburst_i`=0) always gives a pulse.
- R4: Fixed bursts pulse only on their final completed beat. `hburst_i` 2/3 is 4 beats, 4/5 is 8 beats and 6/7 is 16 beats. Wait states and BUSY cycles do not advance the beat count.
- R5: For INCR bursts (`hburst_i`=1), `burst_lim_i` selects a beat limit. The codes are 1 → 1, 2 → 4, 3 → 8, 4 → 16, 5 → 32, 6 → 64 and 7 → 128 beats. A pulse comes on every beat that reaches the limit, and counting then restarts from zero.
- R6: With `burst_lim_i`=0, an INCR burst pulses only on the beat whose next address would cross a 1 KB boundary. From an aligned start, that is beat 256 for word beats (`hsize_i`=2) and beat 128 for double-word beats (`hsize_i`=3).
- R7: Each pulse reloads the slot countdown with `slot_cycle_i`, and the countdown then drops by one per clock. When it reaches zero, the next completed beat pulses. No pulse is given while `hready_i` is low.
- R8: `slot_cycle_i`=0 disables the slot watchdog.
- R9: A NONSEQ beat starts a new count at beat 1, whatever the previous count was.
- R10: The slot countdown resets to its maximum of 255. The first forced break after reset therefore comes 255 clocks after release, provided no other arbitration point occurs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| htrans_i | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonseq, 3 seq |
| hburst_i | input | 3 | Burst type: 0 single, 1 incr, 2..7 wrap/incr 4, 8, 16 |
| hsize_i | input | 3 | Beat size, 2^hsize bytes |
| haddr_i | input | ADDR_W | Beat address |
| hready_i | input | 1 | Transfer completes this cycle |
| burst_lim_i | input | LIM_W | INCR beat limit code, 0 means unlimited |
| slot_cycle_i | input | SLOT_W | Slot length in clocks, 0 disables |
| arb_pt_o | output | 1 | Re-arbitration allowed at this boundary |

## Verification
The bench uses the default parameters: 32-bit addresses, a 3-bit limit code and an 8-bit slot counter with a 1 KB boundary. These values cover the full 128-beat limit and the 256-beat and 128-beat natural breaks at the boundary. They also cover the 255-clock expiry that follows reset. Byte-sized beats at a fixed address are used wherever the boundary must stay out of the way. This keeps the slot and limit checks free of boundary effects over runs of several hundred beats.

// File: rtl/arbpt_pkg.sv
package arbpt_pkg;
  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  localparam logic [2:0] BU_SINGLE = 3'd0;
  localparam logic [2:0] BU_INCR   = 3'd1;
endpackage

// File: rtl/arbpt_beat_trk.sv
module arbpt_beat_trk #(
  parameter int CNT_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         first_i,
  input  logic         flush_i,
  input  logic         brk_i,
  output logic [CNT_W:0] idx_o
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // index of the beat completing now, 1-based
  assign idx_o = first_i ? (CNT_W+1)'(1) : {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) begin
      if (brk_i)                cnt_d = '0;
      else if (idx_o > CNT_MAX) cnt_d = CNT_MAX[CNT_W-1:0];
      else                      cnt_d = idx_o[CNT_W-1:0];
    end else if (flush_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_break_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && brk_i |=> idx_o == (CNT_W+1)'(1));
  p_hold_no_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !flush_i |=> $stable(cnt_q));
endmodule

// File: rtl/arbpt_slot_tmr.sv
module arbpt_slot_tmr #(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [SLOT_W-1:0] slot_cycle_i,
  output logic              expired_o
);
  localparam logic [SLOT_W-1:0] SLOT_RST = {SLOT_W{1'b1}};

  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= SLOT_RST;
    else if (reload_i)      cnt_q <= slot_cycle_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (slot_cycle_i != '0) && (cnt_q == '0);

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(slot_cycle_i));
  p_countdown_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
  p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cycle_i == '0 |-> !expired_o);
endmodule

// File: rtl/arbpt_bnd_det.sv
module arbpt_bnd_det #(
  parameter int BOUND_BYTES = 1024
) (
  input  logic [$clog2(BOUND_BYTES)-1:0] addr_lo_i,
  input  logic [2:0]                     hsize_i,
  output logic                           cross_o
);
  localparam int B = $clog2(BOUND_BYTES);
  localparam logic [B:0] ONE = (B+1)'(1);

  logic [B:0] nxt;

  // next beat address leaves the current boundary window
  assign nxt     = {1'b0, addr_lo_i} + (ONE << hsize_i);
  assign cross_o = nxt[B];
endmodule

// File: rtl/arbpt_gen.sv
module arbpt_gen
  import arbpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LIM_W       = 3,
  parameter int SLOT_W      = 8,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic [2:0]        hsize_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic              hready_i,
  input  logic [LIM_W-1:0]  burst_lim_i,
  input  logic [SLOT_W-1:0] slot_cycle_i,
  output logic              arb_pt_o
);
  localparam int CNT_W = 1 << LIM_W;
  localparam int B     = $clog2(BOUND_BYTES);

  function automatic logic [CNT_W:0] lim_beats(input logic [LIM_W-1:0] code);
    if (code == LIM_W'(1)) return (CNT_W+1)'(1);
    return (CNT_W+1)'(1) << code;
  endfunction

  function automatic logic [CNT_W:0] fixed_beats(input logic [2:0] bu);
    return (CNT_W+1)'(2) << bu[2:1];
  endfunction

  logic           run_q;
  logic           beat_done, is_idle, is_first;
  logic           slot_exp, bnd_cross;
  logic [CNT_W:0] idx;
  logic           hit_single, hit_fixed, hit_lim, hit_bnd;
  logic           unused_addr;

  assign unused_addr = ^haddr_i[ADDR_W-1:B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign beat_done = hready_i && (htrans_i == TR_NONSEQ || htrans_i == TR_SEQ);
  assign is_idle   = hready_i && (htrans_i == TR_IDLE);
  assign is_first  = (htrans_i == TR_NONSEQ);

  arbpt_beat_trk #(.CNT_W(CNT_W)) u_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (beat_done),
    .first_i (is_first),
    .flush_i (is_idle),
    .brk_i   (arb_pt_o),
    .idx_o   (idx)
  );

  arbpt_slot_tmr #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reload_i     (arb_pt_o),
    .slot_cycle_i (slot_cycle_i),
    .expired_o    (slot_exp)
  );

  arbpt_bnd_det #(.BOUND_BYTES(BOUND_BYTES)) u_bnd (
    .addr_lo_i (haddr_i[B-1:0]),
    .hsize_i   (hsize_i),
    .cross_o   (bnd_cross)
  );

  assign hit_single = (hburst_i == BU_SINGLE);
  assign hit_fixed  = (hburst_i[2:1] != 2'b00) && (idx == fixed_beats(hburst_i));
  assign hit_lim    = (hburst_i == BU_INCR) && (burst_lim_i != '0)
                      && (idx == lim_beats(burst_lim_i));
  assign hit_bnd    = (hburst_i == BU_INCR) && bnd_cross;

  assign arb_pt_o = run_q && (is_idle ||
                    (beat_done && (hit_single || hit_fixed || hit_lim || hit_bnd || slot_exp)));

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !arb_pt_o);
  p_idle_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && hready_i && htrans_i == TR_IDLE |-> arb_pt_o);
  p_busy_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_i == TR_BUSY |-> !arb_pt_o);
  p_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && beat_done && hburst_i == BU_SINGLE |-> arb_pt_o);
  p_wait_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |-> !arb_pt_o);
  p_nonseq_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_i == TR_NONSEQ |-> idx == (CNT_W+1)'(1));
endmodule

// File: tb/arbpt_gen_tb.sv
module arbpt_gen_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  htrans = 2'd0;
  logic [2:0]  hburst = 3'd0;
  logic [2:0]  hsize = 3'd0;
  logic [31:0] haddr = '0;
  logic        hready = 1'b1;
  logic [2:0]  lim = 3'd0;
  logic [7:0]  slot = 8'd0;
  logic        arb_pt;
  int          n_run = 0;
  int          n_fail = 0;
  bit          ended = 0;

  always #(CLK_NS/2) clk = ~clk;

  arbpt_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .htrans_i(htrans), .hburst_i(hburst),
    .hsize_i(hsize), .haddr_i(haddr), .hready_i(hready), .burst_lim_i(lim),
    .slot_cycle_i(slot), .arb_pt_o(arb_pt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: arb_pt act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] tr, input logic [2:0] bu, input logic rdy,
                      input logic [31:0] ad, output logic pt);
    @(negedge clk);
    htrans = tr; hburst = bu; hready = rdy; haddr = ad;
    #1 pt = arb_pt;
  endtask

  task automatic idle_gap;
    logic p;
    step(2'd0, 3'd0, 1'b1, 32'd0, p);
  endtask

  task automatic t_reset_r1_r10;
    logic p;
    rst_n = 0; htrans = 2'd0; hready = 1'b1; slot = 8'd8; lim = 3'd0; hsize = 3'd0;
    repeat (3) @(negedge clk);
    #1 chk("R1 during reset", arb_pt, 1'b0);
    rst_n = 1; htrans = 2'd3; hburst = 3'd1;
    #1 chk("R1 after release", arb_pt, 1'b0);
    for (int k = 1; k <= 256; k++) begin
      step(2'd3, 3'd1, 1'b1, 32'd0, p);
      if (k >= 250) chk("R10 reset slot expiry", p, k == 255);
    end
    slot = 8'd0;
    idle_gap();
  endtask

  task automatic t_idle_busy_r2;
    logic p;
    step(2'd0, 3'd0, 1'b1, 32'd0, p); chk("R2 idle ready", p, 1'b1);
    step(2'd0, 3'd0, 1'b0, 32'd0, p); chk("R2 idle wait", p, 1'b0);
    step(2'd1, 3'd1, 1'b1, 32'd0, p); chk("R2 busy", p, 1'b0);
    idle_gap();
  endtask

  task automatic t_single_r3;
    logic p;
    for (int i = 0; i < 3; i++) begin
      step(2'd2, 3'd0, 1'b1, 32'(i*4), p); chk("R3 single", p, 1'b1);
    end
    idle_gap();
  endtask

  task automatic fixed_burst(input logic [2:0] bu, input int len);
    logic p;
    for (int i = 0; i < len; i++) begin
      if (i == 1) begin
        step(2'd3, bu, 1'b0, 32'(i*4), p); chk("R4 wait state", p, 1'b0);
        step(2'd1, bu, 1'b1, 32'(i*4), p); chk("R4 busy", p, 1'b0);
      end
      step(i == 0 ? 2'd2 : 2'd3, bu, 1'b1, 32'(i*4), p);
      chk("R4 fixed burst", p, i == len-1);
    end
    idle_gap();
  endtask

  task automatic t_fixed_r4;
    fixed_burst(3'd3, 4);
    fixed_burst(3'd4, 8);
    fixed_burst(3'd7, 16);
  endtask

  task automatic incr_lim(input logic [2:0] code, input int len);
    logic p;
    lim = code;
    for (int i = 0; i < 2*len + 1; i++) begin
      step(i == 0 ? 2'd2 : 2'd3, 3'd1, 1'b1, 32'd0, p);
      chk("R5 incr limit", p, ((i+1) % len) == 0);
    end
    lim = 3'd0;
    idle_gap();
  endtask

  task automatic t_incr_lim_r5;
    hsize = 3'd0;
    incr_lim(3'd1, 1);
    incr_lim(3'd2, 4);
    incr_lim(3'd4, 16);
    incr_lim(3'd7, 128);
  endtask

  task automatic t_unlim_r6;
    logic p;
    int hits;
    hsize = 3'd2; hits = 0;
    for (int i = 0; i < 256; i++) begin
      step(i == 0 ? 2'd2 : 2'd3, 3'd1, 1'b1, 32'(i*4), p);
      if (p) hits++;
      if (i == 255) chk("R6 word boundary beat 256", p, 1'b1);
    end
    chk("R6 word single break", hits == 1, 1'b1);
    idle_gap();
    hsize = 3'd3; hits = 0;
    for (int i = 0; i < 128; i++) begin
      step(i == 0 ? 2'd2 : 2'd3, 3'd1, 1'b1, 32'(i*8), p);
      if (p) hits++;
      if (i == 127) chk("R6 dword boundary beat 128", p, 1'b1);
    end
    chk("R6 dword single break", hits == 1, 1'b1);
    hsize = 3'd0;
    idle_gap();
  endtask

  task automatic t_nonseq_r9;
    logic p;
    lim = 3'd2;
    for (int i = 0; i < 7; i++) begin
      step((i == 0 || i == 3) ? 2'd2 : 2'd3, 3'd1, 1'b1, 32'd0, p);
      chk("R9 nonseq restart", p, i == 6);
    end
    lim = 3'd0;
    idle_gap();
  endtask

  task automatic t_slot_r7;
    logic p;
    slot = 8'd5;
    step(2'd0, 3'd0, 1'b1, 32'd0, p); chk("R7 reload on idle", p, 1'b1);
    for (int j = 1; j <= 20; j++) begin
      logic rdy;
      rdy = !(j == 18 || j == 19);
      step(j == 1 ? 2'd2 : 2'd3, 3'd1, rdy, 32'd0, p);
      chk("R7 slot expiry", p, j == 6 || j == 12 || j == 20);
    end
    slot = 8'd0;
    idle_gap();
  endtask

  task automatic t_slot_off_r8;
    logic p;
    int hits;
    slot = 8'd0; hits = 0;
    idle_gap();
    for (int i = 0; i < 300; i++) begin
      step(i == 0 ? 2'd2 : 2'd3, 3'd1, 1'b1, 32'd0, p);
      if (p) hits++;
    end
    chk("R8 slot disabled", hits == 0, 1'b1);
    idle_gap();
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset_r1_r10();
    t_idle_busy_r2();
    t_single_r3();
    t_fixed_r4();
    t_incr_lim_r5();
    t_unlim_r6();
    t_nonseq_r9();
    t_slot_r7();
    t_slot_off_r8();
    finish_run();
  end

  initial begin
    #(CLK_NS * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    finish_run();
  end
endmodule